// File: doc/BRIEF.md
# Colour Lookup Table Host Front End

This block holds a colour lookup table of 256 entries and a separate two-entry cursor colour table, and gives the host byte-wide access to both through four register addresses. The host picks an entry by writing an index register. It then moves the three colour components through one data register, red first, then green, then blue. After the blue component the index advances by one, so a run of entries can be loaded or read back without writing the index again. Writes and reads keep separate indices.

An input mode bit sends the same index and data registers to the cursor table instead. In that mode the index never advances. The same mode bit also decides what the control address holds: the pixel mask when the bit is low, a display command byte when it is high.

On the pixel side, an index ANDed with the pixel mask looks up a 24-bit colour, which appears one clock later. A non-zero cursor code overrides this and returns a cursor colour. The table storage is written so that it maps onto dual-port block RAM.

Top module: `clut_host_if`

## Requirements
- R1: After reset the pixel mask reads 0xFF, the command byte reads 0x00, both indices read 0, and the component sequence starts at red.
- R2: Host register map on `host_addr`: 0 = mask/command, 1 = read index, 2 = write index, 3 = data. Three data writes after a write-index write load that entry as red, green, blue. The entry is then seen at `pix_color` as {red[23:16], green[15:8], blue[7:0]}.
- R3: In table mode, each completed three-component write or read advances its own index by one, and the index wraps from 255 to 0.
- R4: After a read-index write, data reads return red, green, then blue of that entry on `host_rdata`, in the cycle after the read strobe. This holds with no idle cycles between reads, and it holds for an entry that was rewritten just before.
- R5: Writing either index register returns the component sequence to red, dropping any partly transferred entry.
- R6: While `cursor_pal_mode` is 1, index bit 0 selects a cursor colour, data accesses read and load that cursor colour, the index does not advance, and the main table is left unchanged.
- R7: Address 0 accesses the pixel mask when `cursor_pal_mode` is 0 and the command byte when it is 1; writing one leaves the other unchanged.
- R8: `pix_color` shows the table entry at `pix_index & mask` one clock after `pix_index` is presented, when `pix_cursor` is 0.
- R9: `pix_cursor` = 01 returns cursor colour 0 and 1x returns cursor colour 1, one clock later, in place of the table lookup.
- R10: A lookup in the same cycle as the host write that completes that entry returns the old colour; the new colour appears from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_addr | input | 2 | Host register select |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| cursor_pal_mode | input | 1 | Sends the index and data registers to the cursor table and address 0 to the command byte |
| pix_index | input | 8 | Pixel colour index |
| pix_cursor | input | 2 | Cursor pixel code, 0 = none |
| pix_color | output | 24 | Looked-up colour, one clock after the index |

## Verification
The assertions take for granted that the host never raises `host_wr` and `host_rd` in the same cycle. They also assume `cursor_pal_mode` changes only while no data access is in progress. The stimulus issues exactly one host access per task call and switches the mode only between whole transfers. Random colours and indices come from a fixed seed. Directed cases cover index wrap, restart of the sequence mid-entry, read-back of a just-written entry, the cursor codes, and a lookup that collides with a write.

// File: rtl/clut_pkg.sv
package clut_pkg;
  typedef enum logic [1:0] {
    REG_CTL  = 2'd0,
    REG_RIDX = 2'd1,
    REG_WIDX = 2'd2,
    REG_DATA = 2'd3
  } host_reg_e;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  localparam int unsigned N_COMP = 3;
  localparam int unsigned N_CURSOR = 2;
endpackage

// File: rtl/clut_ram.sv
module clut_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 24
) (
  input  logic          clk,
  input  logic [AW-1:0] a_addr,
  output logic [DW-1:0] a_q,
  input  logic          b_we,
  input  logic          b_re,
  input  logic [AW-1:0] b_waddr,
  input  logic [AW-1:0] b_raddr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_q
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    a_q <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    if (b_we) mem[b_waddr] <= b_wdata;
    if (b_re) b_q <= mem[b_raddr];
  end
endmodule

// File: rtl/clut_cursor.sv
module clut_cursor #(
  parameter int unsigned DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          wsel,
  input  logic [DW-1:0] wdata,
  input  logic          rsel,
  output logic [DW-1:0] rdata,
  input  logic [1:0]    pix_code,
  output logic          ovr_valid,
  output logic [DW-1:0] ovr_color
);
  logic [DW-1:0] col [clut_pkg::N_CURSOR];

  for (genvar i = 0; i < clut_pkg::N_CURSOR; i++) begin : g_col
    always_ff @(posedge clk) begin
      if (rst) col[i] <= '0;
      else if (we && (wsel == 1'(i))) col[i] <= wdata;
    end
  end

  assign rdata = col[rsel];

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_valid <= 1'b0;
      ovr_color <= '0;
    end else begin
      ovr_valid <= (pix_code != 2'b00);
      ovr_color <= col[pix_code[1]];
    end
  end

  // R9: an override follows a non-zero code by one cycle
  assert_ovr_follows_code_R9: assert property (@(posedge clk) disable iff (rst)
    (pix_code != 2'b00) |=> ovr_valid);
endmodule

// File: rtl/clut_seq.sv
module clut_seq #(
  parameter int unsigned IW = 8,
  parameter int unsigned CW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_wr,
  input  logic            host_rd,
  input  logic [1:0]      host_addr,
  input  logic [CW-1:0]   host_wdata,
  input  logic            cur_mode,
  output logic [CW-1:0]   host_rdata,
  output logic [IW-1:0]   mask,
  output logic            ram_we,
  output logic            ram_re,
  output logic [IW-1:0]   ram_waddr,
  output logic [IW-1:0]   ram_raddr,
  output logic [3*CW-1:0] entry_out,
  input  logic [3*CW-1:0] ram_rq,
  output logic            cur_we,
  output logic            cur_wsel,
  output logic            cur_rsel,
  input  logic [3*CW-1:0] cur_rq
);
  import clut_pkg::*;
  localparam int unsigned EW = 3 * CW;

  host_reg_e      reg_sel;
  phase_e         phase_q, phase_nxt;
  logic [IW-1:0]  wr_idx_q, wr_idx_nxt, rd_idx_q, rd_idx_nxt;
  logic [CW-1:0]  stage_r, stage_g, cmd_q;
  logic           data_wr, data_rd, idx_wr, last, commit;
  logic           byp_v;
  logic [EW-1:0]  byp_d, rd_entry;
  logic [CW-1:0]  rd_comp;

  assign reg_sel = host_reg_e'(host_addr);
  assign data_wr = host_wr && (reg_sel == REG_DATA);
  assign data_rd = host_rd && !host_wr && (reg_sel == REG_DATA);
  assign idx_wr  = host_wr && ((reg_sel == REG_RIDX) || (reg_sel == REG_WIDX));
  assign last    = (phase_q == PH_BLU);
  assign commit  = data_wr && last;

  always_comb begin
    wr_idx_nxt = wr_idx_q;
    if (host_wr && reg_sel == REG_WIDX) wr_idx_nxt = IW'(host_wdata);
    else if (commit && !cur_mode)       wr_idx_nxt = wr_idx_q + 1'b1;
  end

  always_comb begin
    rd_idx_nxt = rd_idx_q;
    if (host_wr && reg_sel == REG_RIDX)   rd_idx_nxt = IW'(host_wdata);
    else if (data_rd && last && !cur_mode) rd_idx_nxt = rd_idx_q + 1'b1;
  end

  always_comb begin
    phase_nxt = phase_q;
    if (idx_wr) phase_nxt = PH_RED;
    else if (data_wr || data_rd) phase_nxt = last ? PH_RED : phase_e'(phase_q + 2'd1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_RED;
      wr_idx_q <= '0;
      rd_idx_q <= '0;
      stage_r  <= '0;
      stage_g  <= '0;
      mask     <= '1;
      cmd_q    <= '0;
    end else begin
      phase_q  <= phase_nxt;
      wr_idx_q <= wr_idx_nxt;
      rd_idx_q <= rd_idx_nxt;
      if (data_wr && phase_q == PH_RED) stage_r <= host_wdata;
      if (data_wr && phase_q == PH_GRN) stage_g <= host_wdata;
      if (host_wr && reg_sel == REG_CTL) begin
        if (cur_mode) cmd_q <= host_wdata;
        else          mask  <= IW'(host_wdata);
      end
    end
  end

  assign entry_out = {stage_r, stage_g, host_wdata};
  assign ram_we    = commit && !cur_mode;
  assign ram_re    = !ram_we;
  assign ram_waddr = wr_idx_q;
  assign ram_raddr = rd_idx_nxt;
  assign cur_we    = commit && cur_mode;
  assign cur_wsel  = wr_idx_q[0];
  assign cur_rsel  = rd_idx_q[0];

  // a commit blocks the prefetch read, so keep the new entry for one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      byp_v <= 1'b0;
      byp_d <= '0;
    end else begin
      byp_v <= ram_we && (wr_idx_q == rd_idx_nxt);
      byp_d <= entry_out;
    end
  end

  assign rd_entry = cur_mode ? cur_rq : (byp_v ? byp_d : ram_rq);

  always_comb begin
    case (phase_q)
      PH_RED:  rd_comp = rd_entry[EW-1 -: CW];
      PH_GRN:  rd_comp = rd_entry[2*CW-1 -: CW];
      default: rd_comp = rd_entry[CW-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else if (host_rd) begin
      case (reg_sel)
        REG_CTL:  host_rdata <= cur_mode ? cmd_q : CW'(mask);
        REG_RIDX: host_rdata <= CW'(rd_idx_q);
        REG_WIDX: host_rdata <= CW'(wr_idx_q);
        default:  host_rdata <= rd_comp;
      endcase
    end
  end

  assert_phase_legal_R2: assert property (@(posedge clk) disable iff (rst)
    phase_q != phase_e'(2'd3));
  assert_autoinc_R3: assert property (@(posedge clk) disable iff (rst)
    (data_wr && last && !cur_mode) |=> (wr_idx_q == $past(wr_idx_q) + 1'b1));
  assert_idx_resets_phase_R5: assert property (@(posedge clk) disable iff (rst)
    idx_wr |=> (phase_q == PH_RED));
  assert_cursor_no_inc_R6: assert property (@(posedge clk) disable iff (rst)
    (cur_mode && (data_wr || data_rd) && !idx_wr) |=>
      ($stable(wr_idx_q) && $stable(rd_idx_q)));
  assert_mask_kept_in_cmd_mode_R7: assert property (@(posedge clk) disable iff (rst)
    cur_mode |=> $stable(mask));
  assert_no_dual_strobe: assert property (@(posedge clk) disable iff (rst)
    !(host_wr && host_rd));
endmodule

// File: rtl/clut_host_if.sv
module clut_host_if #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic [1:0]          host_addr,
  input  logic [COMP_W-1:0]   host_wdata,
  output logic [COMP_W-1:0]   host_rdata,
  input  logic                cursor_pal_mode,
  input  logic [IDX_W-1:0]    pix_index,
  input  logic [1:0]          pix_cursor,
  output logic [3*COMP_W-1:0] pix_color
);
  localparam int unsigned EW = 3 * COMP_W;

  logic [IDX_W-1:0] mask, ram_waddr, ram_raddr;
  logic             ram_we, ram_re, cur_we, cur_wsel, cur_rsel, ovr_valid;
  logic [EW-1:0]    entry, ram_aq, ram_bq, cur_rq, ovr_color;

  clut_seq #(.IW(IDX_W), .CW(COMP_W)) u_seq (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .cur_mode(cursor_pal_mode),
    .host_rdata(host_rdata), .mask(mask), .ram_we(ram_we), .ram_re(ram_re),
    .ram_waddr(ram_waddr), .ram_raddr(ram_raddr), .entry_out(entry),
    .ram_rq(ram_bq), .cur_we(cur_we), .cur_wsel(cur_wsel), .cur_rsel(cur_rsel),
    .cur_rq(cur_rq)
  );

  clut_ram #(.AW(IDX_W), .DW(EW)) u_ram (
    .clk(clk), .a_addr(pix_index & mask), .a_q(ram_aq),
    .b_we(ram_we), .b_re(ram_re), .b_waddr(ram_waddr), .b_raddr(ram_raddr),
    .b_wdata(entry), .b_q(ram_bq)
  );

  clut_cursor #(.DW(EW)) u_cursor (
    .clk(clk), .rst(rst), .we(cur_we), .wsel(cur_wsel), .wdata(entry),
    .rsel(cur_rsel), .rdata(cur_rq), .pix_code(pix_cursor),
    .ovr_valid(ovr_valid), .ovr_color(ovr_color)
  );

  assign pix_color = ovr_valid ? ovr_color : ram_aq;

  // R8: a plain lookup never shows the override path
  assert_plain_lookup_R8: assert property (@(posedge clk) disable iff (rst)
    (pix_cursor == 2'b00) |=> !ovr_valid);
endmodule

// File: tb/clut_host_if_bench.sv
module clut_host_if_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0, cursor_pal_mode = 1'b0;
  logic [1:0]  host_addr = 2'd0, pix_cursor = 2'd0;
  logic [7:0]  host_wdata = 8'd0, pix_index = 8'd0;
  logic [7:0]  host_rdata;
  logic [23:0] pix_color;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;
  logic [23:0] pal [256];
  logic [23:0] curp [2];
  logic [7:0]  mask_m = 8'hFF;

  always #4 clk = ~clk;

  clut_host_if u_clut_host_if (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cursor_pal_mode(cursor_pal_mode), .pix_index(pix_index),
    .pix_cursor(pix_cursor), .pix_color(pix_color)
  );

  function automatic logic [7:0] comp_of(logic [23:0] e, int k);
    return (k == 0) ? e[23:16] : (k == 1) ? e[15:8] : e[7:0];
  endfunction

  function automatic logic [23:0] expect_pix(logic [7:0] idx, logic [1:0] code);
    if (code == 2'b01) return curp[0];
    if (code[1])       return curp[1];
    return pal[idx & mask_m];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hrd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic wr_entry(logic [23:0] e);
    for (int k = 0; k < 3; k++) hwr(2'd3, comp_of(e, k));
  endtask

  task automatic pix(logic [7:0] idx, logic [1:0] code, output logic [23:0] c);
    @(negedge clk);
    pix_index = idx; pix_cursor = code;
    @(negedge clk);
    c = pix_color;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [7:0]  d;
    logic [23:0] c, e, oldc;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    hrd(2'd0, d); chk("R1 mask", d, 8'hFF);
    hrd(2'd1, d); chk("R1 read index", d, 8'h00);
    hrd(2'd2, d); chk("R1 write index", d, 8'h00);
    cursor_pal_mode = 1'b1;
    hrd(2'd0, d); chk("R1 command", d, 8'h00);
    cursor_pal_mode = 1'b0;

    // R2/R3: stream the whole table from index 0, index wraps back to 0
    hwr(2'd2, 8'd0);
    for (int i = 0; i < 256; i++) begin
      pal[i] = 24'($urandom);
      wr_entry(pal[i]);
    end
    hrd(2'd2, d); chk("R3 write index wrap", d, 8'h00);

    // R8 lookups with full mask
    for (int i = 0; i < 40; i++) begin
      logic [7:0] ix = 8'($urandom);
      pix(ix, 2'b00, c); chk("R8 lookup", c, expect_pix(ix, 2'b00));
    end

    // R4 streaming reads without gaps
    begin
      logic [7:0] s = 8'($urandom);
      hwr(2'd1, s);
      for (int j = 0; j < 4; j++)
        for (int k = 0; k < 3; k++) begin
          @(negedge clk); host_rd = 1'b1; host_addr = 2'd3;
          @(negedge clk); host_rd = 1'b0;
          chk("R4 read stream", host_rdata, comp_of(pal[8'(s + j)], k));
        end
    end

    // R3 read index wraps 255 -> 0
    hwr(2'd1, 8'd255);
    for (int k = 0; k < 3; k++) begin hrd(2'd3, d); chk("R3 read 255", d, comp_of(pal[255], k)); end
    hrd(2'd3, d); chk("R3 read wrap", d, comp_of(pal[0], 0));

    // R3 write wraps 255 -> 0
    hwr(2'd2, 8'd255);
    pal[255] = 24'($urandom); wr_entry(pal[255]);
    pal[0]   = 24'($urandom); wr_entry(pal[0]);
    pix(8'd0, 2'b00, c);   chk("R3 write wrap entry 0", c, pal[0]);
    pix(8'd255, 2'b00, c); chk("R3 write 255", c, pal[255]);

    // R8 with a random mask
    mask_m = 8'($urandom) | 8'h11;
    hwr(2'd0, mask_m);
    hrd(2'd0, d); chk("R7 mask readback", d, mask_m);
    for (int i = 0; i < 20; i++) begin
      logic [7:0] ix = 8'($urandom);
      pix(ix, 2'b00, c); chk("R8 masked lookup", c, expect_pix(ix, 2'b00));
    end
    mask_m = 8'hFF; hwr(2'd0, 8'hFF);

    // R5 index write restarts the component sequence
    hwr(2'd2, 8'd10);
    hwr(2'd3, 8'hAA); hwr(2'd3, 8'hBB);
    hwr(2'd2, 8'd10);
    pal[10] = 24'h123456; wr_entry(pal[10]);
    pix(8'd10, 2'b00, c); chk("R5 write restart", c, 24'h123456);
    hrd(2'd2, d); chk("R5 index after restart", d, 8'd11);
    hwr(2'd1, 8'd20);
    hrd(2'd3, d);
    hwr(2'd1, 8'd20);
    hrd(2'd3, d); chk("R5 read restart", d, comp_of(pal[20], 0));

    // R4 read right after rewriting the same entry
    hwr(2'd1, 8'd30); hwr(2'd2, 8'd30);
    pal[30] = 24'($urandom);
    hwr(2'd3, comp_of(pal[30], 0)); hwr(2'd3, comp_of(pal[30], 1));
    @(negedge clk); host_wr = 1'b1; host_addr = 2'd3; host_wdata = comp_of(pal[30], 2);
    @(negedge clk); host_wr = 1'b0; host_rd = 1'b1; host_addr = 2'd3;
    @(negedge clk); host_rd = 1'b0;
    chk("R4 read after rewrite", host_rdata, comp_of(pal[30], 0));

    // R6/R7 cursor mode
    @(negedge clk); cursor_pal_mode = 1'b1;
    hwr(2'd2, 8'd1);
    wr_entry(24'h0F0F0F);
    curp[1] = 24'($urandom); wr_entry(curp[1]);
    hrd(2'd2, d); chk("R6 no write increment", d, 8'd1);
    hwr(2'd1, 8'd1);
    for (int k = 0; k < 3; k++) begin hrd(2'd3, d); chk("R6 cursor read", d, comp_of(curp[1], k)); end
    hrd(2'd1, d); chk("R6 no read increment", d, 8'd1);
    hwr(2'd2, 8'd0);
    curp[0] = 24'($urandom); wr_entry(curp[0]);
    hwr(2'd0, 8'h5C);
    hrd(2'd0, d); chk("R7 command readback", d, 8'h5C);
    @(negedge clk); cursor_pal_mode = 1'b0;
    hrd(2'd0, d); chk("R7 mask kept", d, 8'hFF);
    pix(8'd1, 2'b00, c); chk("R6 table untouched 1", c, pal[1]);
    pix(8'd0, 2'b00, c); chk("R6 table untouched 0", c, pal[0]);

    // R9 cursor codes
    pix(8'd5, 2'b01, c); chk("R9 code 01", c, curp[0]);
    pix(8'd5, 2'b10, c); chk("R9 code 10", c, curp[1]);
    pix(8'd5, 2'b11, c); chk("R9 code 11", c, curp[1]);
    pix(8'd5, 2'b00, c); chk("R9 code 00", c, pal[5]);

    // R10 collision of lookup and committing write
    hwr(2'd2, 8'd77);
    oldc = pal[77];
    e = 24'($urandom);
    hwr(2'd3, comp_of(e, 0)); hwr(2'd3, comp_of(e, 1));
    @(negedge clk);
    host_wr = 1'b1; host_addr = 2'd3; host_wdata = comp_of(e, 2);
    pix_index = 8'd77; pix_cursor = 2'b00;
    @(negedge clk); host_wr = 1'b0;
    chk("R10 same cycle old", pix_color, oldc);
    @(negedge clk);
    chk("R10 next cycle new", pix_color, e);
    pal[77] = e;

    // random mix of entry writes and lookups
    for (int i = 0; i < 60; i++) begin
      logic [7:0] ix = 8'($urandom);
      hwr(2'd2, ix);
      pal[ix] = 24'($urandom); wr_entry(pal[ix]);
      pix(ix, 2'b00, c); chk("R2 random entry", c, pal[ix]);
      hwr(2'd1, ix);
      hrd(2'd3, d); chk("R4 random red", d, comp_of(pal[ix], 0));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule